// File: doc/BRIEF.md
# Strap-Latched Boot Control Register

This block is a 32-bit control and status register whose power-on contents come from board strap pins rather than from constants. When the power-good input rises, it loads a two-bit boot-destination field and a no-reboot bit from three strap pins. After that, software may change them through a simple write port, within the limits of a lock-down bit and a pinned no-reboot strap. The whole register can be read at any time, and it returns live values.

Two small functions use the register contents. A combinational decoder takes a memory address and reports whether that access goes to the PCI, SPI or LPC path. When PCI is selected, the top 16 MB below 4 GB is forced to PCI with no other qualification. The SPI and LPC paths also need an external qualify input. A watchdog gate passes the first-timeout interrupt unchanged. It lets the second-timeout reboot through only while no-reboot is clear.

The power-good input is synchronized and then followed by a three-state sequencer. PG_LOW waits for synchronized power-good. The transition PG_LOW to PG_CAPTURE is taken when synchronized power-good is high. PG_CAPTURE lasts one cycle and loads the straps. The transition PG_CAPTURE to PG_ON is unconditional. The transition PG_ON to PG_LOW is taken when synchronized power-good is low. Reset puts the sequencer in PG_LOW.

Top module: `bootctl_reg`

## Requirements
- R1: While rst_n is low, and after it is released with pwr_good low, rd_data reads 0. In this state all route outputs are 0 whenever dec_qualify is 0.
- R2: If pwr_good is sampled high at rising edge k after being low at edge k-1, the register is loaded at edge k+3. Bit 11 takes strap_dest_hi, bit 10 takes strap_dest_lo and bit 5 takes strap_noreboot. Bits 12, 9 and 0 are cleared. Strap pin changes at any other time have no effect.
- R3: A write changes bits 11:10 only while bit 0 (lock) is clear before the write edge. A write that sets bit 0 and changes bits 11:10 in the same cycle still updates bits 11:10.
- R4: Bit 0, once 1, stays 1 and ignores writes of 0. Only rst_n or a strap capture clears it.
- R5: With bits 11:10 = 10 (PCI), route_pci is 1 exactly when dec_addr[31:24] = FFh, whatever the value of dec_qualify.
- R6: If strap_noreboot was captured high, writes cannot clear bit 5. If it was captured low, writes set and clear bit 5 freely.
- R7: With bits 11:10 = 11, route_spi equals dec_qualify. With bits 11:10 = 00, route_lpc equals dec_qualify. No address condition applies to either.
- R8: wdt_irq always equals wdt_first_to. wdt_reboot equals wdt_second_to while bit 5 is 0, and is 0 while bit 5 is 1.
- R9: Bits 12 and 9 are stored unconditionally from each write and read back as written.
- R10: Bits 31:13, 8:6 and 4:1 read 0 and ignore writes. Encoding 01 in bits 11:10 reads back as 01, and all three route outputs are then 0.
- R11: rd_data and the route outputs are combinational from the register and the inputs. A write with wr_en high at an edge is visible on rd_data right after that edge. At an edge where a capture and a write coincide, the capture wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Power-good input, asynchronous |
| strap_dest_hi | input | 1 | Strap pin for bit 11 |
| strap_dest_lo | input | 1 | Strap pin for bit 10 |
| strap_noreboot | input | 1 | No-reboot strap pin for bit 5 |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register value |
| dec_addr | input | 32 | Address to classify |
| dec_qualify | input | 1 | External range qualifier for SPI and LPC |
| route_pci | output | 1 | Access goes to PCI |
| route_spi | output | 1 | Access goes to SPI |
| route_lpc | output | 1 | Access goes to LPC |
| wdt_first_to | input | 1 | Watchdog first timeout |
| wdt_second_to | input | 1 | Watchdog second timeout |
| wdt_irq | output | 1 | Interrupt request from the first timeout |
| wdt_reboot | output | 1 | Reboot request, gated by bit 5 |

## Verification
The routes, rd_data, wdt_irq and wdt_reboot are due in the same cycle as the inputs that cause them. Register fields change one edge after a write, and strap values appear three edges after pwr_good is first sampled high. The bench drives all inputs on the falling edge. Its reference model advances at each rising edge, using a four-deep history of sampled power-good to place the capture at the third edge. Every output is compared 5 ns after each rising edge, so each result is sampled in the cycle it is due.

// File: rtl/bootctl_pkg.sv
package bootctl_pkg;

    typedef enum logic [1:0] {
        PG_LOW     = 2'd0,
        PG_CAPTURE = 2'd1,
        PG_ON      = 2'd2
    } pg_state_t;

    typedef enum logic [1:0] {
        DEST_LPC  = 2'b00,
        DEST_RSVD = 2'b01,
        DEST_PCI  = 2'b10,
        DEST_SPI  = 2'b11
    } dest_t;

    localparam int REG_W        = 32;
    localparam int BIT_LOCK     = 0;
    localparam int BIT_NOREBOOT = 5;
    localparam int BIT_ERRHOST  = 9;
    localparam int BIT_DEST_LO  = 10;
    localparam int BIT_DEST_HI  = 11;
    localparam int BIT_CAPSEL   = 12;

    typedef struct packed {
        logic  cap_sel;
        dest_t dest;
        logic  err_host;
        logic  no_reboot;
        logic  lock;
    } ctl_t;

endpackage

// File: rtl/bootctl_sync.sv
module bootctl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[TOP-1:0], d};
            end
        end
    endgenerate

    assign q = chain[TOP];
endmodule

// File: rtl/bootctl_seq.sv
module bootctl_seq
    import bootctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pg_sync,
    output logic capture
);
    pg_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PG_LOW;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            PG_LOW:     if (pg_sync)  state_nx = PG_CAPTURE;
            PG_CAPTURE:               state_nx = PG_ON;
            PG_ON:      if (!pg_sync) state_nx = PG_LOW;
            default:                  state_nx = PG_LOW;
        endcase
    end

    always_comb begin
        capture = 1'b0;
        unique case (state)
            PG_CAPTURE: capture = 1'b1;
            default:    capture = 1'b0;
        endcase
    end
endmodule

// File: rtl/bootctl_decode.sv
module bootctl_decode
    import bootctl_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int REGION_BITS = 8
) (
    input  dest_t              dest,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               qualify,
    output logic               to_pci,
    output logic               to_spi,
    output logic               to_lpc
);
    localparam int MSB = ADDR_W - 1;

    logic in_region;
    assign in_region = &addr[MSB -: REGION_BITS];

    always_comb begin
        to_pci = 1'b0;
        to_spi = 1'b0;
        to_lpc = 1'b0;
        unique case (dest)
            DEST_PCI:  to_pci = in_region;
            DEST_SPI:  to_spi = qualify;
            DEST_LPC:  to_lpc = qualify;
            DEST_RSVD: ;
            default:   ;
        endcase
    end
endmodule

// File: rtl/bootctl_reg.sv
module bootctl_reg
    import bootctl_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int SYNC_STAGES = 2,
    parameter int REGION_BITS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    input  logic              strap_dest_hi,
    input  logic              strap_dest_lo,
    input  logic              strap_noreboot,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    input  logic [ADDR_W-1:0] dec_addr,
    input  logic              dec_qualify,
    output logic              route_pci,
    output logic              route_spi,
    output logic              route_lpc,
    input  logic              wdt_first_to,
    input  logic              wdt_second_to,
    output logic              wdt_irq,
    output logic              wdt_reboot
);
    logic pg_sync;
    logic cap_strobe;
    ctl_t ctl;
    logic nr_pinned;
    logic rsvd_unused;

    bootctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pwr_good),
        .q     (pg_sync)
    );

    bootctl_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .pg_sync (pg_sync),
        .capture (cap_strobe)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl       <= '0;
            nr_pinned <= 1'b0;
        end else if (cap_strobe) begin
            ctl.cap_sel   <= 1'b0;
            ctl.dest      <= dest_t'({strap_dest_hi, strap_dest_lo});
            ctl.err_host  <= 1'b0;
            ctl.no_reboot <= strap_noreboot;
            ctl.lock      <= 1'b0;
            nr_pinned     <= strap_noreboot;
        end else if (wr_en) begin
            ctl.cap_sel  <= wr_data[BIT_CAPSEL];
            ctl.err_host <= wr_data[BIT_ERRHOST];
            if (!ctl.lock)
                ctl.dest <= dest_t'(wr_data[BIT_DEST_HI:BIT_DEST_LO]);
            ctl.lock      <= ctl.lock | wr_data[BIT_LOCK];
            ctl.no_reboot <= nr_pinned | wr_data[BIT_NOREBOOT];
        end
    end

    assign rsvd_unused = ^{wr_data[31:13], wr_data[8:6], wr_data[4:1]};

    always_comb begin
        rd_data                           = '0;
        rd_data[BIT_CAPSEL]               = ctl.cap_sel;
        rd_data[BIT_DEST_HI:BIT_DEST_LO]  = ctl.dest;
        rd_data[BIT_ERRHOST]              = ctl.err_host;
        rd_data[BIT_NOREBOOT]             = ctl.no_reboot;
        rd_data[BIT_LOCK]                 = ctl.lock;
    end

    bootctl_decode #(.ADDR_W(ADDR_W), .REGION_BITS(REGION_BITS)) u_dec (
        .dest    (ctl.dest),
        .addr    (dec_addr),
        .qualify (dec_qualify),
        .to_pci  (route_pci),
        .to_spi  (route_spi),
        .to_lpc  (route_lpc)
    );

    assign wdt_irq    = wdt_first_to;
    assign wdt_reboot = wdt_second_to & ~ctl.no_reboot;
endmodule

// File: rtl/bootctl_reg_chk.sv
module bootctl_reg_chk #(
    parameter int ADDR_W      = 32,
    parameter int REGION_BITS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cap,
    input logic              nr_pinned,
    input logic              wr_en,
    input logic [31:0]       rd_data,
    input logic [ADDR_W-1:0] dec_addr,
    input logic              route_pci,
    input logic              route_spi,
    input logic              route_lpc,
    input logic              wdt_second_to,
    input logic              wdt_reboot
);
    localparam logic [31:0] RSVD_MASK = 32'hFFFF_E1DE;

    a_r2_capture_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> !cap);

    a_r3_lock_freezes_dest: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[0] && wr_en && !cap) |=> $stable(rd_data[11:10]));

    a_r4_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[0] && !cap) |=> rd_data[0]);

    a_r5_pci_region: assert property (@(posedge clk) disable iff (!rst_n)
        route_pci |-> (&dec_addr[ADDR_W-1 -: REGION_BITS]));

    a_r6_pinned_noreboot: assert property (@(posedge clk) disable iff (!rst_n)
        nr_pinned |-> rd_data[5]);

    a_r7_single_route: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({route_pci, route_spi, route_lpc}));

    a_r8_reboot_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[5] |-> !wdt_reboot);

    a_r8_reboot_passed: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[5] && wdt_second_to) |-> wdt_reboot);

    a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & RSVD_MASK) == 32'h0);

    a_r10_rsvd_no_route: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[11:10] == 2'b01) |-> !(route_pci || route_spi || route_lpc));
endmodule

bind bootctl_reg bootctl_reg_chk #(.ADDR_W(ADDR_W), .REGION_BITS(REGION_BITS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cap           (cap_strobe),
    .nr_pinned     (nr_pinned),
    .wr_en         (wr_en),
    .rd_data       (rd_data),
    .dec_addr      (dec_addr),
    .route_pci     (route_pci),
    .route_spi     (route_spi),
    .route_lpc     (route_lpc),
    .wdt_second_to (wdt_second_to),
    .wdt_reboot    (wdt_reboot)
);

// File: tb/bootctl_reg_test.sv
module bootctl_reg_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_good = 1'b0;
    logic        strap_dest_hi = 1'b0;
    logic        strap_dest_lo = 1'b0;
    logic        strap_noreboot = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [31:0] dec_addr = '0;
    logic        dec_qualify = 1'b0;
    logic        route_pci, route_spi, route_lpc;
    logic        wdt_first_to = 1'b0;
    logic        wdt_second_to = 1'b0;
    logic        wdt_irq, wdt_reboot;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cycles = 0;
    string phase = "R1";

    bootctl_reg uut (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
        .strap_dest_hi(strap_dest_hi), .strap_dest_lo(strap_dest_lo),
        .strap_noreboot(strap_noreboot),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .dec_addr(dec_addr), .dec_qualify(dec_qualify),
        .route_pci(route_pci), .route_spi(route_spi), .route_lpc(route_lpc),
        .wdt_first_to(wdt_first_to), .wdt_second_to(wdt_second_to),
        .wdt_irq(wdt_irq), .wdt_reboot(wdt_reboot)
    );

    always #10 clk = ~clk;

    // Reference model state
    bit [1:0] m_dest;
    bit m_lock, m_nr, m_pin, m_b12, m_b9;
    bit h1, h2, h3, h4;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_dest = 0; m_lock = 0; m_nr = 0; m_pin = 0; m_b12 = 0; m_b9 = 0;
            h1 = 0; h2 = 0; h3 = 0; h4 = 0;
        end else begin
            if (h3 && !h4) begin
                m_dest = {strap_dest_hi, strap_dest_lo};
                m_nr   = strap_noreboot;
                m_pin  = strap_noreboot;
                m_lock = 0; m_b12 = 0; m_b9 = 0;
            end else if (wr_en) begin
                if (!m_lock) m_dest = wr_data[11:10];
                if (wr_data[0]) m_lock = 1;
                m_nr  = m_pin ? 1'b1 : wr_data[5];
                m_b12 = wr_data[12];
                m_b9  = wr_data[9];
            end
            h4 = h3; h3 = h2; h2 = h1; h1 = pwr_good;
        end
    end

    task automatic cmp1(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", phase, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [31:0] e_rd;
        bit top, e_pci, e_spi, e_lpc;
        e_rd = 0;
        e_rd[12] = m_b12; e_rd[11:10] = m_dest; e_rd[9] = m_b9;
        e_rd[5] = m_nr; e_rd[0] = m_lock;
        top   = (dec_addr >= 32'hFF00_0000);
        e_pci = (m_dest == 2'b10) && top;
        e_spi = (m_dest == 2'b11) && dec_qualify;
        e_lpc = (m_dest == 2'b00) && dec_qualify;
        cmp1("rd_data", rd_data, e_rd);
        cmp1("route_pci", {31'b0, route_pci}, {31'b0, e_pci});
        cmp1("route_spi", {31'b0, route_spi}, {31'b0, e_spi});
        cmp1("route_lpc", {31'b0, route_lpc}, {31'b0, e_lpc});
        cmp1("wdt_irq", {31'b0, wdt_irq}, {31'b0, wdt_first_to});
        cmp1("wdt_reboot", {31'b0, wdt_reboot}, {31'b0, wdt_second_to & ~m_nr});
    endtask

    always begin
        @(posedge clk);
        #5;
        compare_all();
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 32'hDEAD_BEEF;
    endtask

    task automatic probe(input logic [31:0] a, input logic q);
        @(negedge clk);
        dec_addr = a; dec_qualify = q;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        phase = "R1";
        dec_qualify = 1'b0;
        idle(4);
        rst_n = 1'b1;
        idle(4);

        // R2: first capture, straps 11 and no-reboot low, then strap noise
        phase = "R2";
        strap_dest_hi = 1; strap_dest_lo = 1; strap_noreboot = 0;
        @(negedge clk) pwr_good = 1'b1;
        idle(6);
        strap_dest_hi = 0; strap_dest_lo = 1; strap_noreboot = 1;
        idle(4);

        // R9: plain mode bits
        phase = "R9";
        wr(32'h0000_1E00);
        wr(32'h0000_0C00);
        wr(32'h0000_1C00);

        // R10: reserved bits and reserved destination
        phase = "R10";
        wr(32'hFFFF_E5DE);
        probe(32'hFF00_0000, 1); probe(32'h0000_1000, 1); probe(32'hFFFF_FFFF, 0);

        // R5: PCI steering over the top region
        phase = "R5";
        wr(32'h0000_0800);
        probe(32'hFF00_0000, 0); probe(32'hFFFF_FFFF, 1);
        probe(32'hFEFF_FFFF, 1); probe(32'h0000_0000, 0);

        // R7: SPI and LPC need qualify
        phase = "R7";
        wr(32'h0000_0C00);
        probe(32'h1234_0000, 0); probe(32'h1234_0000, 1); probe(32'hFF80_0000, 0);
        wr(32'h0000_0000);
        probe(32'h0000_0000, 1); probe(32'hFFF0_0000, 0); probe(32'hFFF0_0000, 1);

        // R6 and R8 with no-reboot strap low
        phase = "R6";
        wr(32'h0000_0020);
        wr(32'h0000_0000);
        phase = "R8";
        wdt_first_to = 1; idle(1); wdt_second_to = 1; idle(2);
        wr(32'h0000_0020);
        idle(2);
        wdt_first_to = 0; idle(1);
        wr(32'h0000_0000);
        wdt_second_to = 0; idle(2);

        // R3: lock set together with a destination change
        phase = "R3";
        wr(32'h0000_0801);
        wr(32'h0000_0C01);
        wr(32'h0000_0400);
        probe(32'hFF00_0001, 1);

        // R4: writing 0 keeps lock
        phase = "R4";
        wr(32'h0000_0000);
        wr(32'h0000_1200);

        // R11: write visible right after the edge, then recapture clears lock
        phase = "R11";
        @(negedge clk) pwr_good = 1'b0;
        idle(6);
        strap_dest_hi = 0; strap_dest_lo = 0; strap_noreboot = 1;
        @(negedge clk) pwr_good = 1'b1;
        idle(2);
        wr_en = 1'b1; wr_data = 32'h0000_1E01;
        idle(1);
        wr_en = 1'b0;
        idle(4);

        // R6: pinned no-reboot strap
        phase = "R6";
        strap_noreboot = 0;
        wr(32'h0000_0000);
        wr(32'h0000_0C00);
        phase = "R8";
        wdt_first_to = 1; wdt_second_to = 1; idle(3);
        wdt_first_to = 0; wdt_second_to = 0; idle(1);

        // R2: capture of destination 10 after lock
        phase = "R2";
        wr(32'h0000_0001);
        @(negedge clk) pwr_good = 1'b0;
        idle(6);
        strap_dest_hi = 1; strap_dest_lo = 0; strap_noreboot = 0;
        @(negedge clk) pwr_good = 1'b1;
        idle(6);
        probe(32'hFF12_3456, 0);
        wr(32'h0000_0400);
        idle(3);

        finish_run();
    end
endmodule